// File: doc/BRIEF.md
# Nonvolatile Memory Command Status Unit

This unit holds the status and interrupt state of a nonvolatile memory command controller and shows it to software through two memory-mapped registers. A command engine elsewhere signals when a command begins and when it ends, and whether it succeeded. The unit turns those events into four status bits: a live busy indication and three sticky bits for success, failure and completion interrupt. It also drives an interrupt line that follows the interrupt bit.

Software reads the status register to learn the outcome of the last command. That read returns the outcome and also clears the sticky bits. The busy bit is left alone by reads. A read/write mode register holds the completion interrupt enable. If the enable is clear, a command still completes and records its result, but no interrupt is raised.

Register reads are registered: the data appears on `rd_data` one clock after the read strobe. Any sticky clear caused by that read takes effect at the same edge.

Top module: `nvm_status_unit`

## Requirements
- R1: After reset the status register reads 0x0020 (bit 5 is a reserved bit that always reads 1; every other bit reads 0), the mode register reads 0x0000 and `irq` is low.
- R2: A `cmd_start` pulse while idle sets status bit 2 (busy). Busy stays set until a completion is accepted, and status reads do not change it.
- R3: A `cmd_done` pulse while busy clears busy. It sets status bit 0 (pass) when `cmd_ok` is 1 and status bit 1 (fail) when `cmd_ok` is 0.
- R4: Pass, fail and interrupt status are sticky. A status register read returns their current values and clears them, so the next read shows them cleared.
- R5: An accepted `cmd_start` clears any pass or fail bit left from the previous command.
- R6: Status bit 3 (interrupt status) is set by an accepted completion only when mode register bit 3 (interrupt enable) is 1. When that enable bit is 0, a completion leaves bit 3 clear.
- R7: `irq` is high exactly while status bit 3 is set, so it drops in the cycle after a status register read.
- R8: If a completion is accepted in the same cycle as a status register read, the read returns the old status. The bits set by the new completion remain set after the read.
- R9: The mode register is a 16-bit read/write register at MODE_ADDR. A write to the status address has no effect on any status bit.
- R10: A `cmd_done` pulse while idle is ignored: no status bit changes.
- R11: A read of any address other than the two registers returns 0x0000 and clears no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after `bus_rd` |
| cmd_start | input | 1 | Command engine began a command (one-cycle pulse) |
| cmd_done | input | 1 | Command engine finished a command (one-cycle pulse) |
| cmd_ok | input | 1 | Result qualifying `cmd_done`: 1 pass, 0 fail |
| irq | output | 1 | Completion interrupt, level |

## Verification
A wrong sticky bit is visible at the ports in two ways. `irq` shows it one edge after the faulty completion. A status read shows it on `rd_data` one edge after the strobe, and a second read shows whether the clear really happened. A busy flag that fails to track the engine shows up in the next status read. It also shows up as a completion that was wrongly ignored or wrongly accepted, leaving the pass and fail bits unchanged or set. The collision of a completion with a read is checked on both reads around it, because a wrong priority is visible only in the second one.

// File: rtl/nvm_status_pkg.sv
// Package: shared bit positions and widths for the status unit.
// Assumes a 16-bit register data path.
package nvm_status_pkg;
    localparam int REG_W      = 16;
    localparam int BIT_PASS   = 0;
    localparam int BIT_FAIL   = 1;
    localparam int BIT_BUSY   = 2;
    localparam int BIT_INT    = 3;
    localparam int BIT_FIXED  = 5;   // reserved bit, reads as one
    localparam logic [REG_W-1:0] STAT_RESET = REG_W'(1) << BIT_FIXED;

    // Decoded register access for one cycle.
    typedef struct packed {
        logic stat_rd;
        logic mode_rd;
        logic mode_wr;
    } reg_hit_t;
endpackage

// File: rtl/nvm_reg_decode.sv
// Module: address decoder for the status unit's register window.
// Assumes single-cycle strobes; reads and writes may not need to be exclusive.
module nvm_reg_decode
    import nvm_status_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'hFFFF_0E00,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 32'hFFFF_0804
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_hit_t          hit
);
    logic is_stat;
    logic is_mode;

    // Compare the address against both register locations.
    always_comb begin
        is_stat     = (addr == STAT_ADDR);
        is_mode     = (addr == MODE_ADDR);
        hit.stat_rd = rd & is_stat;
        hit.mode_rd = rd & is_mode;
        hit.mode_wr = wr & is_mode;
    end
endmodule

// File: rtl/nvm_busy_track.sv
// Module: tracks whether the command engine is working and qualifies its events.
// Assumes start and done arrive as one-cycle pulses; a start while busy and a
// done while idle are dropped.
module nvm_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic start_acc,
    output logic done_acc,
    output logic busy
);
    // Accept only the events that fit the current state.
    always_comb begin
        start_acc = start & ~busy;
        done_acc  = done & busy;
    end

    // Busy register: set by an accepted start, cleared by an accepted done.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_acc) busy <= 1'b1;
        else if (done_acc)  busy <= 1'b0;
    end

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy);
    p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |=> !busy);
    p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !start) |=> !busy);
endmodule

// File: rtl/nvm_sticky_flags.sv
// Module: pass, fail and interrupt sticky flags.
// Assumes clr is the status register read strobe. Within one cycle a read is
// applied first, then a start, then a completion, so a new event survives.
module nvm_sticky_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start_acc,
    input  logic done_acc,
    input  logic done_ok,
    input  logic int_en,
    output logic pass_q,
    output logic fail_q,
    output logic int_q
);
    logic pass_n;
    logic fail_n;
    logic int_n;

    // Next-state of each sticky bit in priority order.
    always_comb begin
        pass_n = pass_q;
        fail_n = fail_q;
        int_n  = int_q;
        if (clr) begin
            pass_n = 1'b0;
            fail_n = 1'b0;
            int_n  = 1'b0;
        end
        if (start_acc) begin
            pass_n = 1'b0;
            fail_n = 1'b0;
        end
        if (done_acc) begin
            pass_n = done_ok;
            fail_n = ~done_ok;
            if (int_en) int_n = 1'b1;
        end
    end

    // Sticky bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            int_q  <= 1'b0;
        end else begin
            pass_q <= pass_n;
            fail_q <= fail_n;
            int_q  <= int_n;
        end
    end

    p_result_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q));
    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done_acc) |=> (!pass_q && !fail_q && !int_q));
    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (!pass_q && !fail_q));
    p_int_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && !int_en && !int_q) |=> !int_q);
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && clr) |=> (pass_q || fail_q));
endmodule

// File: rtl/nvm_status_unit.sv
// Module: top of the status unit. It holds the mode register, assembles the
// status word and registers read data.
// Assumes one register access per cycle and read data taken one cycle later.
module nvm_status_unit
    import nvm_status_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'hFFFF_0E00,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 32'hFFFF_0804,
    parameter int                IEN_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cmd_start,
    input  logic              cmd_done,
    input  logic              cmd_ok,
    output logic              irq
);
    reg_hit_t           hit;
    logic               start_acc;
    logic               done_acc;
    logic               busy;
    logic               pass_q;
    logic               fail_q;
    logic               int_q;
    logic [REG_W-1:0]   mode_q;
    logic [REG_W-1:0]   status;

    nvm_reg_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .MODE_ADDR(MODE_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .hit (hit)
    );

    nvm_busy_track u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .done     (cmd_done),
        .start_acc(start_acc),
        .done_acc (done_acc),
        .busy     (busy)
    );

    nvm_sticky_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hit.stat_rd),
        .start_acc(start_acc),
        .done_acc (done_acc),
        .done_ok  (cmd_ok),
        .int_en   (mode_q[IEN_BIT]),
        .pass_q   (pass_q),
        .fail_q   (fail_q),
        .int_q    (int_q)
    );

    // Mode register: written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (hit.mode_wr) mode_q <= bus_wdata;
    end

    // Assemble the status word from the live and sticky bits.
    always_comb begin
        status            = STAT_RESET;
        status[BIT_PASS]  = pass_q;
        status[BIT_FAIL]  = fail_q;
        status[BIT_BUSY]  = busy;
        status[BIT_INT]   = int_q;
    end

    // Read data register: captures the addressed value at the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           rd_data <= '0;
        else if (hit.stat_rd) rd_data <= status;
        else if (hit.mode_rd) rd_data <= mode_q;
        else if (bus_rd)      rd_data <= '0;
    end

    // Interrupt line follows the interrupt status bit.
    always_comb irq = int_q;

    p_irq_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.stat_rd && !done_acc) |=> !irq);
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit.mode_wr |=> $stable(mode_q));
    p_other_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit.stat_rd && !hit.mode_rd) |=> (rd_data == '0));
    p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit.stat_rd |=> rd_data[BIT_FIXED]);
endmodule

// File: tb/nvm_status_unit_bench.sv
module nvm_status_unit_bench;
    localparam logic [31:0] STAT_A = 32'hFFFF_0E00;
    localparam logic [31:0] MODE_A = 32'hFFFF_0804;
    localparam logic [31:0] OTHR_A = 32'hFFFF_0E04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic        cmd_start = 1'b0;
    logic        cmd_done = 1'b0;
    logic        cmd_ok = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nvm_status_unit u_nvm_status_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .irq(irq)
    );

    // Vector: {int enable, result ok, expected irq, expected status}
    localparam logic [18:0] VEC [4] = '{
        {1'b1, 1'b1, 1'b1, 16'h0029},
        {1'b1, 1'b0, 1'b1, 16'h002A},
        {1'b0, 1'b1, 1'b0, 16'h0021},
        {1'b0, 1'b0, 1'b0, 16'h0022}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Read: strobe one cycle, data sampled at the next falling edge.
    task automatic rd(input logic [31:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_done(input logic ok);
        @(negedge clk); cmd_done = 1'b1; cmd_ok = ok;
        @(negedge clk); cmd_done = 1'b0;
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {15'b0, irq}, 16'h0000);
        rd(STAT_A, d); check("R1 status", d, 16'h0020);
        rd(MODE_A, d); check("R1 mode", d, 16'h0000);

        // Table walk: R2, R3, R4, R6, R7
        for (int i = 0; i < 4; i++) begin
            wr(MODE_A, {12'b0, VEC[i][18], 3'b0});
            pulse_start();
            rd(STAT_A, d); check("R2 busy", d, 16'h0024);
            rd(STAT_A, d); check("R2 busy kept by read", d, 16'h0024);
            pulse_done(VEC[i][17]);
            check("R6/R7 irq", {15'b0, irq}, {15'b0, VEC[i][16]});
            rd(STAT_A, d); check("R3/R6 status", d, VEC[i][15:0]);
            check("R7 irq after read", {15'b0, irq}, 16'h0000);
            rd(STAT_A, d); check("R4 cleared", d, 16'h0020);
        end

        // R8 completion collides with a status read
        wr(MODE_A, 16'h0008);
        pulse_start();
        @(negedge clk);
        cmd_done = 1'b1; cmd_ok = 1'b1; bus_addr = STAT_A; bus_rd = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0; bus_rd = 1'b0;
        check("R8 old status", rd_data, 16'h0024);
        check("R8 irq kept", {15'b0, irq}, 16'h0001);
        rd(STAT_A, d); check("R8 new bits survive", d, 16'h0029);

        // R5 start clears previous result
        wr(MODE_A, 16'h0000);
        pulse_start();
        pulse_done(1'b0);
        pulse_start();
        rd(STAT_A, d); check("R5 result cleared", d, 16'h0024);
        pulse_done(1'b1);
        rd(STAT_A, d); check("R5 pass", d, 16'h0021);

        // R10 done while idle
        pulse_done(1'b1);
        rd(STAT_A, d); check("R10 idle done", d, 16'h0020);

        // R9 mode readback and writes to status
        wr(MODE_A, 16'hABC5);
        rd(MODE_A, d); check("R9 mode rw", d, 16'hABC5);
        wr(STAT_A, 16'hFFFF);
        rd(STAT_A, d); check("R9 status write ignored", d, 16'h0020);
        wr(MODE_A, 16'h0000);

        // R11 other address: zero and no clear
        pulse_start();
        pulse_done(1'b1);
        rd(OTHR_A, d); check("R11 other read", d, 16'h0000);
        rd(STAT_A, d); check("R11 no clear", d, 16'h0021);

        // R1 reset mid-operation
        wr(MODE_A, 16'h0008);
        pulse_start();
        pulse_done(1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", {15'b0, irq}, 16'h0000);
        rd(STAT_A, d); check("R1 status after reset", d, 16'h0020);
        rd(MODE_A, d); check("R1 mode after reset", d, 16'h0000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule